// File: doc/BRIEF.md
# Dual-Channel Compare Timer

The block provides two independent 32-bit up-counters. Each channel has a clock-divided count, a compare value and an interrupt line. Software reaches all state through a single-cycle 32-bit register bus. A write takes effect at the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`. Each channel's control word holds three enable bits and a 16-bit divisor D. With counting enabled, the channel's counter advances once every D+1 clock cycles.

When an advance makes a channel's count equal to its compare value, and the channel's match enable is set, the channel's bit in a shared status register is set. That bit stays set until software clears it by writing a 1 to it. The channel's interrupt output is high whenever its status bit and its interrupt enable are both 1. Software usually stops a channel, writes its counter (usually to zero), loads a compare value, and then sets all three enable bits. The reset is asynchronous and active low. It is expected to be released synchronously to `clk` by the surrounding logic.

Top module: `match_timer`

## Requirements
- R1: After reset, every register reads as 0 and both interrupt outputs are low.
- R2: Channel n (n = 0, 1) has its control word at byte address 0x00+4n, its compare value at 0x18+4n and its counter at 0x48+4n. The status register is at 0x60. Control bit 0 enables counting, bit 1 enables the interrupt output and bit 2 enables the match event. Bits [31:16] hold the divisor D. Control bits [15:3] read as 0. Any unmapped address reads as 0.
- R3: While control bit 0 is 1, the counter advances by one on every (D+1)-th clock edge. While bit 0 is 0, the counter holds its value.
- R4: The divider phase starts again from zero when bit 0 goes from 0 to 1, and also when software writes the counter. The first advance therefore comes D+1 edges after either event.
- R5: A counter write loads the written value, even on an edge where the counter would have advanced. A counter write never sets the status bit, even if the written value equals the compare value.
- R6: When control bit 2 is 1 and an advance makes the count equal to the compare value, status bit n is set at that same edge. When bit 2 is 0, no match sets the status bit.
- R7: Interrupt output n is high exactly when status bit n is 1 and control bit 1 of channel n is 1. Clearing bit 1 masks the output but leaves the status bit unchanged.
- R8: In the status register, writing 1 to bit n clears that bit and writing 0 leaves it unchanged. Writing 0xFFFF clears both bits.
- R9: If a match sets a status bit at the same edge where software clears it, the bit ends up set.
- R10: The counter wraps from 0xFFFFFFFF to 0 and keeps counting. A compare value is matched again after the wrap.
- R11: The two channels are independent. Activity on one channel changes neither the counter nor the status bit of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 2 | Interrupt line per channel |

## Verification
Some rules are checked by assertions on every cycle. A counter holds while stopped, steps by exactly one on each divider tick, and loads written data ahead of an advance. A match event always leaves its status bit set, even against a simultaneous clear. A status bit that is cleared without a match falls, and one with neither event keeps its value. Other behaviour needs the bench's scenarios with exact edge counts. These cover the real spacing of advances for several divisors, the phase restart on enable and on a counter write, the masking of the interrupt without losing the status bit, and the wrap that re-fires a compare value. The register layout and the independence of the channels are also shown there.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_BASE  = 'h00;
  localparam int CMP_BASE   = 'h18;
  localparam int CNT_BASE   = 'h48;
  localparam int STAT_ADDR  = 'h60;
  localparam int ADDR_STEP  = 4;

  typedef struct packed {
    logic match_en;  // bit 2
    logic irq_en;    // bit 1
    logic run;       // bit 0
  } ctrl_bits_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q, phase_d;
  logic             wrap;

  assign wrap = (phase_q >= div);
  assign tick = run && !restart && wrap;

  always_comb begin
    if (!run || restart || wrap) phase_d = '0;
    else                         phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assert_phase_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || restart) |=> (phase_q == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             cmp_we,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] ctrl_rd,
  output logic [CNT_W-1:0] cmp_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_en,
  output logic             match_evt
);
  localparam int PAD_W = CNT_W - DIV_W - 3;

  ctrl_bits_t       ctrl_q, ctrl_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] cmp_d, cnt_d, cnt_inc;
  logic             tick;

  tmr_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run),
    .restart (cnt_we),
    .div     (div_q),
    .tick    (tick)
  );

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    ctrl_d = ctrl_q;
    div_d  = div_q;
    if (ctrl_we) begin
      ctrl_d = ctrl_bits_t'(wdata[2:0]);
      div_d  = wdata[CNT_W-1 -: DIV_W];
    end
  end

  always_comb begin
    cmp_d = cmp_we ? wdata : cmp_q;
    if (cnt_we)    cnt_d = wdata;
    else if (tick) cnt_d = cnt_inc;
    else           cnt_d = cnt_q;
  end

  assign match_evt = ctrl_q.match_en && tick && !cnt_we && (cnt_inc == cmp_q);
  assign irq_en    = ctrl_q.irq_en;
  assign ctrl_rd   = {div_q, {PAD_W{1'b0}}, ctrl_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
      cmp_q  <= '0;
      cnt_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      div_q  <= div_d;
      cmp_q  <= cmp_d;
      cnt_q  <= cnt_d;
    end
  end

  assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !cnt_we) |=> $stable(cnt_q));
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  assert_load_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_q == $past(wdata)));
  assert_no_evt_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |-> !match_evt);
endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt,
  input  logic [NUM_CH-1:0] clr,
  output logic [NUM_CH-1:0] status
);
  logic [NUM_CH-1:0] status_d;

  assign status_d = (status & ~clr) | evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_d;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      evt[n] |=> status[n]);
    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[n] && !evt[n]) |=> !status[n]);
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr[n] && !evt[n]) |=> $stable(status[n]));
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic [DATA_W-1:0] ctrl_rd [NUM_CH];
  logic [DATA_W-1:0] cmp_rd  [NUM_CH];
  logic [DATA_W-1:0] cnt_rd  [NUM_CH];
  logic [NUM_CH-1:0] ctrl_hit, cmp_hit, cnt_hit, irq_en, evt, clr, status;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_BASE + ADDR_STEP * n);
    localparam logic [ADDR_W-1:0] CMP_A  = ADDR_W'(CMP_BASE  + ADDR_STEP * n);
    localparam logic [ADDR_W-1:0] CNT_A  = ADDR_W'(CNT_BASE  + ADDR_STEP * n);

    assign ctrl_hit[n] = (bus_addr == CTRL_A);
    assign cmp_hit[n]  = (bus_addr == CMP_A);
    assign cnt_hit[n]  = (bus_addr == CNT_A);

    tmr_channel #(.CNT_W(DATA_W), .DIV_W(DIV_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_we   (bus_we && ctrl_hit[n]),
      .cmp_we    (bus_we && cmp_hit[n]),
      .cnt_we    (bus_we && cnt_hit[n]),
      .wdata     (bus_wdata),
      .ctrl_rd   (ctrl_rd[n]),
      .cmp_q     (cmp_rd[n]),
      .cnt_q     (cnt_rd[n]),
      .irq_en    (irq_en[n]),
      .match_evt (evt[n])
    );

    assign irq[n] = status[n] && irq_en[n];

    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && ctrl_hit[n] && !bus_wdata[1]) |=> !irq[n]);
  end

  assign clr = (bus_we && bus_addr == STAT_A) ? bus_wdata[NUM_CH-1:0] : '0;

  tmr_status #(.NUM_CH(NUM_CH)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .clr    (clr),
    .status (status)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == STAT_A) bus_rdata = DATA_W'(status);
    for (int n = 0; n < NUM_CH; n++) begin
      if (ctrl_hit[n]) bus_rdata = ctrl_rd[n];
      if (cmp_hit[n])  bus_rdata = cmp_rd[n];
      if (cnt_hit[n])  bus_rdata = cnt_rd[n];
    end
  end
endmodule

// File: tb/tb_match_timer.sv
module tb_match_timer;
  localparam logic [7:0] A_CTRL = 8'h00, A_CMP = 8'h18, A_CNT = 8'h48, A_STAT = 8'h60;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  match_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [15:0] div;
    logic [31:0] start;
    logic [15:0] waitn;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'd0,  32'd0,          16'd7,  32'd7},
    '{16'd1,  32'd10,         16'd7,  32'd13},
    '{16'd4,  32'h100,        16'd12, 32'h102},
    '{16'd2,  32'hFFFF_FFFF,  16'd3,  32'd0},
    '{16'd15, 32'd5,          16'd16, 32'd6},
    '{16'd3,  32'd40,         16'd3,  32'd40}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v, ch0_hold;
    bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; rst_n = 1'b0;
    edges(3);
    @(negedge clk) rst_n = 1'b1;
    edges(1);

    // R1 reset state
    foreach (VECS[i]) begin end
    for (int a = 0; a < 8'h64; a += 4) begin
      rd(8'(a), v);
      check("R1 reset register", v, 32'd0);
    end
    check("R1 irq after reset", {30'd0, irq}, 32'd0);

    // R2 layout and readback
    wr(A_CTRL + 8'd4, 32'hABCD_FFF8);
    rd(A_CTRL + 8'd4, v); check("R2 ctrl reserved bits read 0", v, 32'hABCD_0000);
    wr(A_CMP, 32'h1234_5678);
    rd(A_CMP, v); check("R2 compare readback", v, 32'h1234_5678);
    rd(A_CMP + 8'd4, v); check("R2 other compare untouched", v, 32'd0);
    rd(8'h10, v); check("R2 unmapped read", v, 32'd0);
    wr(A_CTRL + 8'd4, 32'd0);

    // R3 table: count rate for several divisors
    for (int i = 0; i < 6; i++) begin
      logic [7:0] off;
      off = (i % 2 == 1) ? 8'd4 : 8'd0;
      wr(A_CTRL + off, 32'd0);
      wr(A_CNT + off, VECS[i].start);
      wr(A_CTRL + off, {VECS[i].div, 16'h0001});
      edges(int'(VECS[i].waitn));
      rd(A_CNT + off, v);
      check("R3 count after divided edges", v, VECS[i].exp);
    end
    wr(A_CTRL, 32'd0); wr(A_CTRL + 8'd4, 32'd0);

    // R4 phase restart on enable and on counter write
    wr(A_CNT, 32'd0);
    wr(A_CTRL, {16'd3, 16'h0001});
    edges(6);
    rd(A_CNT, v); check("R4 first advance after D+1 edges", v, 32'd1);
    wr(A_CNT, 32'd100);
    edges(3);
    rd(A_CNT, v); check("R4 R5 loaded value, phase restarted", v, 32'd100);
    edges(1);
    rd(A_CNT, v); check("R4 advance D+1 edges after load", v, 32'd101);
    wr(A_CTRL, 32'd0);
    rd(A_CNT, v); check("R3 stop keeps value", v, 32'd101);
    edges(10);
    rd(A_CNT, v); check("R3 hold while stopped", v, 32'd101);

    // R6 R7 R8 match, irq masking, write-one-to-clear
    wr(A_STAT, 32'hFFFF);
    wr(A_CMP, 32'd5);
    wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h7);
    edges(4);
    rd(A_STAT, v); check("R6 no status before match", v, 32'd0);
    check("R7 no irq before match", {30'd0, irq}, 32'd0);
    edges(1);
    rd(A_STAT, v); check("R6 status set at match edge", v, 32'd1);
    rd(A_CNT, v);  check("R6 count equals compare", v, 32'd5);
    check("R7 irq asserted", {30'd0, irq}, 32'd1);
    wr(A_CTRL, 32'h5);
    check("R7 irq masked", {30'd0, irq}, 32'd0);
    rd(A_STAT, v); check("R7 status kept while masked", v, 32'd1);
    wr(A_CTRL, 32'h7);
    check("R7 irq returns on unmask", {30'd0, irq}, 32'd1);
    wr(A_STAT, 32'h2);
    rd(A_STAT, v); check("R8 zero bit leaves status", v, 32'd1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); check("R8 one bit clears status", v, 32'd0);
    wr(A_CTRL, 32'd0);

    // R6 match disabled on channel 1
    wr(A_CMP + 8'd4, 32'd3);
    wr(A_CNT + 8'd4, 32'd0);
    wr(A_CTRL + 8'd4, 32'h3);
    edges(5);
    rd(A_STAT, v); check("R6 match enable clear blocks status", v, 32'd0);
    check("R6 no irq without match enable", {30'd0, irq}, 32'd0);
    wr(A_CTRL + 8'd4, 32'd0);

    // R5 counter write equal to compare does not set status
    wr(A_CTRL + 8'd4, 32'h6);
    wr(A_CNT + 8'd4, 32'd3);
    edges(2);
    rd(A_STAT, v); check("R5 load equal to compare sets nothing", v, 32'd0);
    wr(A_CTRL + 8'd4, 32'd0);

    // R9 set wins over same-edge clear
    wr(A_CMP, 32'd10);
    wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h7);
    edges(9);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); check("R9 set wins over clear", v, 32'd1);
    rd(A_CNT, v);  check("R9 count at match edge", v, 32'd10);
    wr(A_STAT, 32'hFFFF);
    rd(A_STAT, v); check("R8 0xFFFF clears all", v, 32'd0);
    wr(A_CTRL, 32'd0);
    rd(A_CNT, ch0_hold);

    // R10 wrap and re-match, R11 independence
    wr(A_CMP + 8'd4, 32'd1);
    wr(A_CNT + 8'd4, 32'hFFFF_FFFE);
    wr(A_CTRL + 8'd4, 32'h7);
    edges(2);
    rd(A_CNT + 8'd4, v); check("R10 wrap to zero", v, 32'd0);
    rd(A_STAT, v); check("R10 no status before re-match", v, 32'd0);
    edges(1);
    rd(A_STAT, v); check("R10 match after wrap", v, 32'h2);
    check("R11 only channel 1 irq", {30'd0, irq}, 32'h2);
    rd(A_CNT, v); check("R11 channel 0 count untouched", v, ch0_hold);
    wr(A_STAT, 32'h2);
    rd(A_STAT, v); check("R8 clear channel 1", v, 32'd0);

    done = 1'b1;
    finish_run();
  end
endmodule